// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Two Prescaler

This block watches for software that has stopped running. It counts ticks from one of two sources. The first is a free-running pulse from a dedicated low-speed oscillator. The second is the core clock divided by four. The ticks pass through a prescaler whose ratio is selectable in powers of two from 1:1 to 1:128, and then into a fixed 8-bit final counter. When the final counter wraps, the block signals a time-out.

While the device runs, a time-out produces a one-cycle reset request. While the device is halted, a time-out produces a one-cycle wake request instead. Software restarts the chain by issuing clear commands. A mode input decides whether one command is enough, or whether both commands must arrive, in either order, before the chain restarts.

Two sticky status flags report what happened:
- The time-out flag records that a time-out occurred.
- The power-down flag records that the device entered halt.

An accepted clear command drops both flags. A halt request clears the counter chain and sets the power-down flag. An external wake event ends the halted state. A single enable option disables the whole timer.

Top module: `wdog_core`

## Requirements
- R1: After reset, `rst_req`, `wake_req`, `to_flag`, `pd_flag` and `halted` are all 0.
- R2: When `src_sel` is 0, the source is the core clock divided by four. At prescaler code r, the `rst_req` pulse becomes visible right after the (1024·2^r)-th rising clock edge following the edge that accepted a clear.
- R3: When `src_sel` is 1, the source is the dedicated tick. Each cycle with `osc_tick` high is one tick, and a time-out follows exactly 256·2^r ticks after the clearing edge.
- R4: `ratio_sel` holds the binary code r (0 to 7), and the prescaler divides by 2^r: 0 gives 1:1, 3 gives 1:8, 7 gives 1:128.
- R5: A time-out while running raises `rst_req` for exactly one cycle. On the same edge it sets `to_flag`, and `wake_req` stays low.
- R6: With `dual_mode` 0, either `clr_a` or `clr_b` alone restarts the counter chain and clears both `to_flag` and `pd_flag` on the next edge.
- R7: With `dual_mode` 1, the chain restarts only once both `clr_a` and `clr_b` have been seen, in either order or together. Repeating one command alone does not restart it.
- R8: `halt_req` while not halted sets `halted` and `pd_flag` and clears the counter chain. With the divided core clock as source, the chain does not advance while halted.
- R9: With the dedicated tick as source, a time-out while halted raises `wake_req` for one cycle instead of `rst_req`, sets `to_flag`, and clears `halted`.
- R10: `ext_wake` while halted clears `halted`. Counting then resumes from the cleared chain.
- R11: With `en_opt` 0, the chain is held at zero and no `rst_req` or `wake_req` is produced. After re-enabling, the full time-out period elapses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_opt | input | 1 | Watchdog enable option |
| src_sel | input | 1 | Tick source: 0 = core clock / 4, 1 = dedicated tick |
| osc_tick | input | 1 | One-cycle pulses from the dedicated oscillator, synchronous to `clk` |
| ratio_sel | input | RSEL_W | Prescaler code r, divide by 2^r |
| dual_mode | input | 1 | 1 = both clear commands needed |
| clr_a | input | 1 | Clear command A (pulse) |
| clr_b | input | 1 | Clear command B (pulse) |
| halt_req | input | 1 | Device enters halt (pulse) |
| ext_wake | input | 1 | Other wake source ends halt (pulse) |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake request from halt |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |
| halted | output | 1 | Block considers the device halted |

## Verification
The assertions check on every cycle how the requests and flags relate to each other:
- the single-cycle shape of `rst_req`;
- `to_flag` accompanying every request;
- the exclusive reset and wake forms;
- the state reached after halt entry, after an external wake and after a single-mode clear;
- the silence of a disabled timer.

Only the bench scenarios can show the exact time-out periods for each source and prescaler code. The same holds for the dual-clear sequencing with repeated or reordered commands, the frozen chain during a halt on the divided clock, and the restart from zero after a wake or re-enable.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic {
    SRC_QUARTER = 1'b0,
    SRC_OSC     = 1'b1
  } wd_src_e;

  // Low-bit mask selecting a 2^r division out of a binary prescaler.
  function automatic logic [31:0] ratio_mask(input logic [31:0] r);
    return (32'd1 << r) - 32'd1;
  endfunction

  // Final-stage counter sits on its last value.
  function automatic logic at_top(input logic [31:0] cnt, input int unsigned w);
    return cnt == ((32'd1 << w) - 32'd1);
  endfunction

endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel #(
  parameter int QDIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic zero,
  input  logic sys_run,
  input  logic src_sel,
  input  logic osc_tick,
  output logic tick
);
  import wdog_pkg::*;

  logic [QDIV_W-1:0] qdiv;
  logic              quarter_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        qdiv <= '0;
    else if (zero)     qdiv <= '0;
    else if (sys_run)  qdiv <= qdiv + 1'b1;
  end

  assign quarter_tick = sys_run && (qdiv == '1);

  always_comb begin
    if (hold)                         tick = 1'b0;
    else if (wd_src_e'(src_sel) == SRC_OSC) tick = osc_tick;
    else                              tick = quarter_tick;
  end

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int RSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero,
  input  logic              tick,
  input  logic [RSEL_W-1:0] ratio,
  output logic              hit
);
  import wdog_pkg::*;

  localparam int PRE_W = (1 << RSEL_W) - 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] mask;

  assign mask = PRE_W'(ratio_mask(32'(ratio)));
  assign hit  = tick && ((pre_cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pre_cnt <= '0;
    else if (zero)  pre_cnt <= '0;
    else if (tick)  pre_cnt <= pre_cnt + 1'b1;
  end

endmodule

// File: rtl/wdog_final.sv
module wdog_final #(
  parameter int FIN_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zero,
  input  logic step,
  output logic ovf
);
  import wdog_pkg::*;

  logic [FIN_W-1:0] cnt;

  assign ovf = step && at_top(32'(cnt), FIN_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (zero)  cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/wdog_clr_ctl.sv
module wdog_clr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic dual_mode,
  input  logic clr_a,
  input  logic clr_b,
  output logic accept
);
  logic arm_a, arm_b;

  always_comb begin
    if (dual_mode) accept = (arm_a || clr_a) && (arm_b || clr_b);
    else           accept = clr_a || clr_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_a <= 1'b0;
      arm_b <= 1'b0;
    end else if (!dual_mode || accept) begin
      arm_a <= 1'b0;
      arm_b <= 1'b0;
    end else begin
      arm_a <= arm_a || clr_a;
      arm_b <= arm_b || clr_b;
    end
  end

endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int RSEL_W = 3,
  parameter int FIN_W  = 8,
  parameter int QDIV_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_opt,
  input  logic              src_sel,
  input  logic              osc_tick,
  input  logic [RSEL_W-1:0] ratio_sel,
  input  logic              dual_mode,
  input  logic              clr_a,
  input  logic              clr_b,
  input  logic              halt_req,
  input  logic              ext_wake,
  output logic              rst_req,
  output logic              wake_req,
  output logic              to_flag,
  output logic              pd_flag,
  output logic              halted
);

  // Named internal events
  logic clr_ok;      // clear command accepted
  logic halt_entry;  // halt begins this cycle
  logic chain_hold;  // no tick may be counted
  logic chain_zero;  // counter chain returns to zero
  logic sys_run;     // divided core clock is running
  logic tick;        // selected source tick
  logic pre_hit;     // prescaler output pulse
  logic tmo;         // final-stage wrap

  assign halt_entry = halt_req && !halted;
  assign chain_hold = clr_ok || halt_entry || !en_opt;
  assign chain_zero = chain_hold || tmo;
  assign sys_run    = en_opt && !halted;

  wdog_clr_ctl u_clr (
    .clk       (clk),
    .rst_n     (rst_n),
    .dual_mode (dual_mode),
    .clr_a     (clr_a),
    .clr_b     (clr_b),
    .accept    (clr_ok)
  );

  wdog_tick_sel #(.QDIV_W(QDIV_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (chain_hold),
    .zero     (chain_zero),
    .sys_run  (sys_run),
    .src_sel  (src_sel),
    .osc_tick (osc_tick),
    .tick     (tick)
  );

  wdog_prescale #(.RSEL_W(RSEL_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .zero  (chain_zero),
    .tick  (tick),
    .ratio (ratio_sel),
    .hit   (pre_hit)
  );

  wdog_final #(.FIN_W(FIN_W)) u_fin (
    .clk   (clk),
    .rst_n (rst_n),
    .zero  (chain_zero),
    .step  (pre_hit),
    .ovf   (tmo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      to_flag  <= 1'b0;
      pd_flag  <= 1'b0;
      halted   <= 1'b0;
    end else begin
      rst_req  <= tmo && !halted;
      wake_req <= tmo && halted;

      if (tmo)         to_flag <= 1'b1;
      else if (clr_ok) to_flag <= 1'b0;

      if (halt_entry)  pd_flag <= 1'b1;
      else if (clr_ok) pd_flag <= 1'b0;

      if (halted) halted <= !(ext_wake || tmo);
      else        halted <= halt_req;
    end
  end

endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk (
  input logic clk,
  input logic rst_n,
  input logic en_opt,
  input logic dual_mode,
  input logic clr_a,
  input logic clr_b,
  input logic halt_req,
  input logic ext_wake,
  input logic rst_req,
  input logic wake_req,
  input logic to_flag,
  input logic pd_flag,
  input logic halted
);

  a_r5_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r5_rst_sets_to: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (to_flag && !wake_req));

  a_r6_single_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_mode && (clr_a || clr_b) && !(halt_req && !halted)) |=> (!to_flag && !pd_flag));

  a_r8_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !halted) |=> (halted && pd_flag));

  a_r9_wake_form: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (to_flag && !halted && !rst_req));

  a_r10_ext_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && ext_wake) |=> !halted);

  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_opt |=> (!rst_req && !wake_req));

endmodule

bind wdog_core wdog_core_chk u_chk (.*);

// File: tb/sim_wdog_core.sv
`timescale 1ns/1ps
module sim_wdog_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_opt = 1'b1;
  logic       src_sel = 1'b0;
  logic       osc_tick = 1'b0;
  logic [2:0] ratio_sel = 3'd0;
  logic       dual_mode = 1'b0;
  logic       clr_a = 1'b0;
  logic       clr_b = 1'b0;
  logic       halt_req = 1'b0;
  logic       ext_wake = 1'b0;
  logic       rst_req, wake_req, to_flag, pd_flag, halted;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_core u0 (
    .clk(clk), .rst_n(rst_n), .en_opt(en_opt), .src_sel(src_sel),
    .osc_tick(osc_tick), .ratio_sel(ratio_sel), .dual_mode(dual_mode),
    .clr_a(clr_a), .clr_b(clr_b), .halt_req(halt_req), .ext_wake(ext_wake),
    .rst_req(rst_req), .wake_req(wake_req), .to_flag(to_flag),
    .pd_flag(pd_flag), .halted(halted)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Hold the given command inputs for one rising edge; entered and left at a falling edge.
  task automatic drive(input logic a, input logic b, input logic h, input logic w);
    clr_a = a; clr_b = b; halt_req = h; ext_wake = w;
    @(posedge clk);
    @(negedge clk);
    clr_a = 0; clr_b = 0; halt_req = 0; ext_wake = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Count rising edges until a request is seen or the limit is reached.
  task automatic wait_evt(input int limit, output int n, output bit r, output bit w);
    n = 0; r = 0; w = 0;
    while (n < limit && !r && !w) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      r = rst_req;
      w = wake_req;
    end
  endtask

  task automatic t_reset();
    check(rst_req == 0 && wake_req == 0, "R1 requests", int'(rst_req) + int'(wake_req), 0);
    check(to_flag == 0 && pd_flag == 0, "R1 flags", int'(to_flag) + int'(pd_flag), 0);
    check(halted == 0, "R1 halted", int'(halted), 0);
  endtask

  task automatic t_quarter(input int r);
    int n; bit gr, gw;
    src_sel = 0; ratio_sel = 3'(r); dual_mode = 0;
    drive(1, 0, 0, 0);
    wait_evt(20000, n, gr, gw);
    check(gr && !gw, "R2 reset request seen", int'(gr), 1);
    check(n == 1024 * (1 << r), "R2 R4 quarter-clock period", n, 1024 * (1 << r));
    check(to_flag == 1, "R5 to_flag set", int'(to_flag), 1);
    idle(1);
    check(rst_req == 0, "R5 single-cycle reset request", int'(rst_req), 0);
  endtask

  task automatic t_single_clear();
    int n; bit gr, gw;
    dual_mode = 0; src_sel = 0; ratio_sel = 0;
    drive(0, 1, 0, 0);
    check(to_flag == 0, "R6 clr_b clears to_flag", int'(to_flag), 0);
    idle(700);
    drive(0, 1, 0, 0);
    wait_evt(5000, n, gr, gw);
    check(gr && n == 1024, "R6 clr_b restarts chain", n, 1024);
  endtask

  task automatic t_osc(input int r);
    int n; bit gr, gw;
    src_sel = 1; osc_tick = 1; ratio_sel = 3'(r); dual_mode = 0;
    drive(1, 0, 0, 0);
    wait_evt(40000, n, gr, gw);
    check(gr && n == 256 * (1 << r), "R3 R4 dedicated-tick period", n, 256 * (1 << r));
    osc_tick = 0; src_sel = 0;
  endtask

  task automatic t_dual();
    int n; bit gr, gw;
    src_sel = 0; ratio_sel = 0; dual_mode = 1;
    drive(1, 1, 0, 0);
    idle(600);
    drive(1, 0, 0, 0);
    drive(1, 0, 0, 0);
    wait_evt(5000, n, gr, gw);
    check(gr && n == 422, "R7 repeated single command ignored", n, 422);
    for (int o = 0; o < 2; o++) begin
      drive(1, 1, 0, 0);
      idle(600);
      if (o == 0) drive(1, 0, 0, 0); else drive(0, 1, 0, 0);
      idle(100);
      if (o == 0) drive(0, 1, 0, 0); else drive(1, 0, 0, 0);
      wait_evt(5000, n, gr, gw);
      check(gr && n == 1024, "R7 both commands restart chain", n, 1024);
    end
    dual_mode = 0;
  endtask

  task automatic t_halt_quarter();
    int n; bit gr, gw;
    src_sel = 0; ratio_sel = 0; dual_mode = 0;
    drive(1, 0, 0, 0);
    drive(0, 0, 1, 0);
    check(halted == 1 && pd_flag == 1, "R8 halt entry flags", int'(halted) + int'(pd_flag), 2);
    wait_evt(3000, n, gr, gw);
    check(!gr && !gw, "R8 chain frozen while halted", int'(gr) + int'(gw), 0);
    drive(0, 0, 0, 1);
    check(halted == 0, "R10 ext_wake ends halt", int'(halted), 0);
    wait_evt(5000, n, gr, gw);
    check(gr && n == 1024, "R10 resume from cleared chain", n, 1024);
  endtask

  task automatic t_halt_osc();
    int n; bit gr, gw;
    src_sel = 1; osc_tick = 1; ratio_sel = 3'd1; dual_mode = 0;
    drive(1, 0, 0, 0);
    idle(50);
    drive(0, 0, 1, 0);
    wait_evt(5000, n, gr, gw);
    check(gw && !gr, "R9 wake request instead of reset", int'(gw), 1);
    check(n == 512, "R9 halt entry cleared chain", n, 512);
    check(halted == 0 && to_flag == 1 && pd_flag == 1, "R9 state after wake",
          int'(halted) * 4 + int'(to_flag) * 2 + int'(pd_flag), 3);
    idle(1);
    check(wake_req == 0, "R9 single-cycle wake", int'(wake_req), 0);
    drive(1, 0, 0, 0);
    check(to_flag == 0 && pd_flag == 0, "R6 clear drops both flags", int'(to_flag) + int'(pd_flag), 0);
    osc_tick = 0; src_sel = 0;
  endtask

  task automatic t_disabled();
    int n; bit gr, gw;
    src_sel = 0; ratio_sel = 0;
    en_opt = 0;
    wait_evt(2000, n, gr, gw);
    check(!gr && !gw, "R11 disabled is silent", int'(gr) + int'(gw), 0);
    en_opt = 1;
    wait_evt(5000, n, gr, gw);
    check(gr && n == 1024, "R11 full period after enable", n, 1024);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    t_quarter(0);
    t_quarter(1);
    t_single_clear();
    t_osc(3);
    t_osc(7);
    t_dual();
    t_halt_quarter();
    t_halt_osc();
    t_disabled();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule